// File: doc/BRIEF.md
# Multi-Mode Serial Channel with Reload Baud Timer

This block is one full-duplex serial channel. It sends and receives at the same time, and each direction has one holding register in front of its shift register. The channel can run in one of two framings. In the asynchronous framing, each frame has a start bit, the data bits least-significant first, an optional extra bit and one stop bit. In the clock-synchronous framing, the block drives a shift clock and moves the data bits only. In the asynchronous framing the extra bit carries either parity or a multiprocessor address/data flag. A wake-up filter can drop every frame whose flag marks it as data.

Bit timing comes from a baud tick. A 16-bit down-counter produces the tick by reloading from `cfgReload`, or the block takes one tick per rising edge of an external clock pin. The asynchronous receiver oversamples at sixteen ticks per bit and decides each bit by a three-sample majority vote. It returns each word through a valid/ready port together with parity-error, framing-error, address and overrun flags. The transmit word enters through a valid/ready port.

Top module: `uart_multimode`

## Requirements
- R1: After reset `txd` and `sclk` are 1, `txReady` is 1, and `rxValid` and `rxOverrun` are 0.
- R2: The data length comes from `cfgLenSel`. Without parity, 0/1/2 give 7/8/9 bits. With parity, 0/1/2 give 6/7/8 bits. A value of 3 acts as 2. Bits above the length read as 0 in `rxData` and are not sent.
- R3: An asynchronous frame is a start bit of 0, then the data bits with bit 0 first, then the extra bit when parity or multiprocessor mode is on, then one stop bit of 1. Each bit lasts 16 baud ticks.
- R4: With `cfgExtClk`=0, a baud tick occurs every `cfgReload`+1 clock cycles. With `cfgExtClk`=1, a tick occurs once per rising edge of `extClk`.
- R5: With parity on, the parity bit makes the count of ones in data plus parity even when `cfgParOdd`=0 and odd when it is 1. A received word that breaks this rule has `rxParErr`=1.
- R6: A received stop bit that is voted 0 sets `rxFrmErr`=1 with that word.
- R7: The receiver samples each bit at ticks 7, 8 and 9 of the bit and takes the majority. A start bit that is voted 1 is abandoned and delivers nothing.
- R8: `txReady` returns to 1 as soon as the held word moves into the shift register, while that frame is still being sent. A received word stays on `rxData` with `rxValid`=1 until it is taken with `rxReady`.
- R9: When a frame completes while the receive holding register is still full, the new frame is discarded, the held word is kept, and `rxOverrun` stays 1 until the held word is taken.
- R10: Multiprocessor mode (`cfgMulti`=1) forces 8 data bits and no parity. The extra bit is taken from `txAddr` and reported on `rxAddr`. With `cfgWake`=1, frames whose flag is 0 are dropped.
- R11: In synchronous mode `sclk` idles at 1. Each data bit gets one falling and one rising `sclk` edge, one tick apart. `rxd` is sampled on the rising edge. Every word sent produces one received word of the same length, and no start, stop or extra bit is used.
- R12: Transmission and reception run at the same time. A frame looped from `txd` to `rxd` is received intact while the next word is already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSync | input | 1 | 1 selects clock-synchronous transfer |
| cfgLenSel | input | 2 | Data length select |
| cfgParEn | input | 1 | Parity bit enable (asynchronous, non-multiprocessor) |
| cfgParOdd | input | 1 | 1 selects odd parity |
| cfgMulti | input | 1 | Multiprocessor address/data flag mode |
| cfgWake | input | 1 | Drop frames flagged as data |
| cfgExtClk | input | 1 | Take baud ticks from `extClk` |
| cfgReload | input | 16 | Baud counter reload value |
| extClk | input | 1 | External baud clock |
| txData | input | 9 | Word to send |
| txAddr | input | 1 | Flag bit sent with the word in multiprocessor mode |
| txValid | input | 1 | Transmit word offered |
| txReady | output | 1 | Transmit holding register free |
| rxData | output | 9 | Received word |
| rxAddr | output | 1 | Received flag bit (multiprocessor mode) |
| rxParErr | output | 1 | Parity mismatch in the held word |
| rxFrmErr | output | 1 | Stop bit was 0 for the held word |
| rxOverrun | output | 1 | A frame was lost while the word was held |
| rxValid | output | 1 | Receive holding register full |
| rxReady | input | 1 | Consumer takes the held word |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| sclk | output | 1 | Shift clock in synchronous mode |

## Verification
The bench keeps the default parameters: a 9-bit data path, a 16-bit reload counter and 16 samples per bit. It drives `cfgReload` to 3, so one bit lasts 64 clock cycles. A whole frame then takes well under a thousand cycles, which leaves room to run every length, both parity senses, multiprocessor filtering, overrun, a false start, the synchronous mode and the external-clock path in one run. The external clock toggles every 10 cycles, which gives a 320-cycle bit whose start-bit width the bench measures on `txd`.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             txStart;
    logic             txStep;
    logic             rxBit;
    logic             rxEnd;
    logic             rxVal;
    logic [IDX_W-1:0] rxIdx;
  } strobe_t;

  function automatic logic [IDX_W-1:0] dataLen(input logic [1:0] sel,
                                               input logic par,
                                               input logic multi);
    logic [1:0] s;
    s = (sel == 2'd3) ? 2'd2 : sel;
    if (multi) return IDX_W'(8);
    return (par ? IDX_W'(6) : IDX_W'(7)) + IDX_W'(s);
  endfunction
endpackage

// File: rtl/uart_mm_ctrl.sv
module uart_mm_ctrl
  import uart_mm_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int OVS     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgSync,
  input  logic               cfgExtClk,
  input  logic [TIMER_W-1:0] cfgReload,
  input  logic               extClk,
  input  logic               rxd,
  input  logic [IDX_W-1:0]   lenBits,
  input  logic [IDX_W-1:0]   frameBits,
  input  logic               txFull,
  output strobe_t            str,
  output logic               sclk
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SMP_A    = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SMP_B    = SUB_W'(OVS / 2);
  localparam logic [SUB_W-1:0] SMP_C    = SUB_W'(OVS / 2 + 1);

  logic [TIMER_W-1:0] baudCnt;
  logic [2:0]         extSync;
  logic               rxMeta, rxLine, tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudCnt <= '0;
      extSync <= '0;
      rxMeta  <= 1'b1;
      rxLine  <= 1'b1;
    end else begin
      extSync <= {extSync[1:0], extClk};
      rxMeta  <= rxd;
      rxLine  <= rxMeta;
      baudCnt <= (baudCnt == '0) ? cfgReload : baudCnt - 1'b1;
    end
  end

  assign tick = cfgExtClk ? (extSync[1] & ~extSync[2]) : (baudCnt == '0);

  // transmit sequencing
  logic             txBusy, sclkR, endPend, syncFin;
  logic [SUB_W-1:0] txSub;
  logic [IDX_W-1:0] txCnt, txLast;

  assign txLast  = cfgSync ? lenBits - 1'b1 : frameBits + 1'b1;
  assign syncFin = cfgSync && txBusy && tick && !sclkR && (txCnt == txLast);
  assign sclk    = sclkR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txSub   <= '0;
      txCnt   <= '0;
      sclkR   <= 1'b1;
      endPend <= 1'b0;
    end else begin
      endPend <= syncFin;
      if (str.txStart) begin
        txBusy <= 1'b1;
        txSub  <= '0;
        txCnt  <= '0;
      end else if (txBusy && tick) begin
        if (cfgSync) begin
          sclkR <= ~sclkR;
          if (!sclkR) begin
            txCnt <= txCnt + 1'b1;
            if (txCnt == txLast) txBusy <= 1'b0;
          end
        end else begin
          txSub <= txSub + 1'b1;
          if (txSub == SUB_LAST) begin
            txCnt <= txCnt + 1'b1;
            if (txCnt == txLast) txBusy <= 1'b0;
          end
        end
      end
    end
  end

  // asynchronous receive sequencing
  logic             rxBusy, vote, voteNow;
  logic [SUB_W-1:0] rxSub;
  logic [IDX_W-1:0] rxIdx;
  logic [1:0]       smp;

  assign vote    = (smp[0] & smp[1]) | (smp[0] & rxLine) | (smp[1] & rxLine);
  assign voteNow = rxBusy && tick && (rxSub == SMP_C);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxSub  <= '0;
      rxIdx  <= '0;
      smp    <= 2'b11;
    end else if (cfgSync) begin
      rxBusy <= 1'b0;
    end else if (!rxBusy) begin
      if (tick && !rxLine) begin
        rxBusy <= 1'b1;
        rxSub  <= '0;
        rxIdx  <= '0;
      end
    end else if (tick) begin
      rxSub <= rxSub + 1'b1;
      if (rxSub == SMP_A) smp[0] <= rxLine;
      if (rxSub == SMP_B) smp[1] <= rxLine;
      if (rxSub == SUB_LAST) rxIdx <= rxIdx + 1'b1;
      if (voteNow && ((rxIdx == '0 && vote) || rxIdx == frameBits + 1'b1))
        rxBusy <= 1'b0;
    end
  end

  always_comb begin
    str = '0;
    str.txStart = !txBusy && txFull;
    if (cfgSync) begin
      if (txBusy && tick) begin
        if (sclkR) begin
          str.txStep = (txCnt != '0);
        end else begin
          str.rxBit  = 1'b1;
          str.rxIdx  = txCnt;
          str.rxVal  = rxLine;
          str.txStep = (txCnt == txLast);
        end
      end
      if (endPend) begin
        str.rxEnd = 1'b1;
        str.rxVal = 1'b1;
      end
    end else begin
      str.txStep = txBusy && tick && (txSub == SUB_LAST);
      if (voteNow && rxIdx != '0) begin
        str.rxVal = vote;
        if (rxIdx == frameBits + 1'b1) str.rxEnd = 1'b1;
        else begin
          str.rxBit = 1'b1;
          str.rxIdx = rxIdx - 1'b1;
        end
      end
    end
  end

  p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cfgExtClk && tick && cfgReload != '0 |=> !tick);

  p_sclk_on_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(sclkR));
endmodule

// File: rtl/uart_mm_dp.sv
module uart_mm_dp
  import uart_mm_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSync,
  input  logic              effPar,
  input  logic              cfgParOdd,
  input  logic              effMulti,
  input  logic              cfgWake,
  input  logic [IDX_W-1:0]  lenBits,
  input  strobe_t           str,
  input  logic [DATA_W-1:0] txData,
  input  logic              txAddr,
  input  logic              txValid,
  output logic              txFull,
  output logic [DATA_W-1:0] rxData,
  output logic              rxAddr,
  output logic              rxParErr,
  output logic              rxFrmErr,
  output logic              rxOverrun,
  output logic              rxFull,
  input  logic              rxReady,
  output logic              txd
);
  localparam int SH_W = DATA_W + 3;
  localparam int RX_W = DATA_W + 1;

  logic [DATA_W-1:0] lenMask, txHold, txWord, rxWord;
  logic [SH_W-1:0]   holdX, frameV, txShift;
  logic [RX_W-1:0]   rxShift;
  logic              txHoldAddr, extBit, hasExt;
  logic              rxExt, parBad, drop, pop;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) lenMask[i] = (i < int'(lenBits));
  end

  assign txWord = txHold & lenMask;
  assign holdX  = SH_W'(txWord);
  assign hasExt = effPar | effMulti;
  assign extBit = effMulti ? txHoldAddr : (^txWord ^ cfgParOdd);

  always_comb begin
    frameV[0] = cfgSync ? holdX[0] : 1'b0;
    for (int p = 1; p < SH_W; p++) begin
      if (cfgSync)                              frameV[p] = (p < int'(lenBits)) ? holdX[p] : 1'b1;
      else if (p - 1 < int'(lenBits))           frameV[p] = holdX[p-1];
      else if (p - 1 == int'(lenBits) && hasExt) frameV[p] = extBit;
      else                                      frameV[p] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold     <= '0;
      txHoldAddr <= 1'b0;
      txFull     <= 1'b0;
      txShift    <= '1;
    end else begin
      if (txValid && !txFull) begin
        txHold     <= txData;
        txHoldAddr <= txAddr;
        txFull     <= 1'b1;
      end
      if (str.txStart) begin
        txShift <= frameV;
        txFull  <= 1'b0;
      end else if (str.txStep) begin
        txShift <= {1'b1, txShift[SH_W-1:1]};
      end
    end
  end

  assign txd = txShift[0];

  assign rxWord = rxShift[DATA_W-1:0] & lenMask;
  assign rxExt  = rxShift[lenBits];
  assign parBad = effPar && (^rxWord ^ rxExt ^ cfgParOdd);
  assign drop   = effMulti && cfgWake && !rxExt;
  assign pop    = rxFull && rxReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift   <= '0;
      rxData    <= '0;
      rxAddr    <= 1'b0;
      rxParErr  <= 1'b0;
      rxFrmErr  <= 1'b0;
      rxOverrun <= 1'b0;
      rxFull    <= 1'b0;
    end else begin
      if (str.rxBit) rxShift[str.rxIdx] <= str.rxVal;
      if (pop) begin
        rxFull    <= 1'b0;
        rxOverrun <= 1'b0;
      end
      if (str.rxEnd && !drop) begin
        if (rxFull && !pop) begin
          rxOverrun <= 1'b1;
        end else begin
          rxData    <= rxWord;
          rxAddr    <= effMulti && rxExt;
          rxParErr  <= parBad;
          rxFrmErr  <= !cfgSync && !str.rxVal;
          rxOverrun <= 1'b0;
          rxFull    <= 1'b1;
        end
      end
    end
  end

  p_keep_buffer_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxFull && !rxReady |=> rxFull && $stable(rxData));

  p_valid_after_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(str.rxEnd));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    str.txStart && !cfgSync |=> !txd);

  p_hold_taken_r8: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txFull |=> txFull);
endmodule

// File: rtl/uart_multimode.sv
module uart_multimode
  import uart_mm_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int TIMER_W = 16,
  parameter int OVS     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgSync,
  input  logic [1:0]         cfgLenSel,
  input  logic               cfgParEn,
  input  logic               cfgParOdd,
  input  logic               cfgMulti,
  input  logic               cfgWake,
  input  logic               cfgExtClk,
  input  logic [TIMER_W-1:0] cfgReload,
  input  logic               extClk,
  input  logic [DATA_W-1:0]  txData,
  input  logic               txAddr,
  input  logic               txValid,
  output logic               txReady,
  output logic [DATA_W-1:0]  rxData,
  output logic               rxAddr,
  output logic               rxParErr,
  output logic               rxFrmErr,
  output logic               rxOverrun,
  output logic               rxValid,
  input  logic               rxReady,
  output logic               txd,
  input  logic               rxd,
  output logic               sclk
);
  logic             effPar, effMulti, txFull;
  logic [IDX_W-1:0] lenBits, frameBits;
  strobe_t          str;

  assign effMulti  = cfgMulti & ~cfgSync;
  assign effPar    = cfgParEn & ~effMulti & ~cfgSync;
  assign lenBits   = dataLen(cfgLenSel, effPar, effMulti);
  assign frameBits = lenBits + IDX_W'(effPar | effMulti);
  assign txReady   = ~txFull;

  uart_mm_ctrl #(.TIMER_W(TIMER_W), .OVS(OVS)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgSync(cfgSync), .cfgExtClk(cfgExtClk),
    .cfgReload(cfgReload), .extClk(extClk), .rxd(rxd), .lenBits(lenBits),
    .frameBits(frameBits), .txFull(txFull), .str(str), .sclk(sclk)
  );

  uart_mm_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cfgSync(cfgSync), .effPar(effPar),
    .cfgParOdd(cfgParOdd), .effMulti(effMulti), .cfgWake(cfgWake),
    .lenBits(lenBits), .str(str), .txData(txData), .txAddr(txAddr),
    .txValid(txValid), .txFull(txFull), .rxData(rxData), .rxAddr(rxAddr),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .rxOverrun(rxOverrun),
    .rxFull(rxValid), .rxReady(rxReady), .txd(txd)
  );
endmodule

// File: tb/tb_uart_multimode.sv
module tb_uart_multimode;
  localparam int RELOAD = 3;
  localparam int P      = 16 * (RELOAD + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgSync = 0, cfgParEn = 0, cfgParOdd = 0, cfgMulti = 0, cfgWake = 0, cfgExtClk = 0;
  logic [1:0]  cfgLenSel = 2'd1;
  logic [15:0] cfgReload = 16'(RELOAD);
  logic extClk = 0, extRun = 0;
  logic [8:0] txData = '0;
  logic txAddr = 0, txValid = 0, rxReady = 1;
  logic txReady, rxAddr, rxParErr, rxFrmErr, rxOverrun, rxValid, txd, sclk;
  logic [8:0] rxData;
  logic loop = 0, benchRxd = 1;
  wire  rxdIn = loop ? txd : benchRxd;

  int total = 0, bad = 0, fallCnt = 0;

  typedef struct { logic [8:0] d; logic a; logic p; logic f; string tag; } expT;
  expT expQ[$];

  uart_multimode dut (
    .clk(clk), .rstN(rstN), .cfgSync(cfgSync), .cfgLenSel(cfgLenSel),
    .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd), .cfgMulti(cfgMulti),
    .cfgWake(cfgWake), .cfgExtClk(cfgExtClk), .cfgReload(cfgReload),
    .extClk(extClk), .txData(txData), .txAddr(txAddr), .txValid(txValid),
    .txReady(txReady), .rxData(rxData), .rxAddr(rxAddr), .rxParErr(rxParErr),
    .rxFrmErr(rxFrmErr), .rxOverrun(rxOverrun), .rxValid(rxValid),
    .rxReady(rxReady), .txd(txd), .rxd(rxdIn), .sclk(sclk)
  );

  always #5 clk = ~clk;

  initial forever begin
    repeat (10) @(negedge clk);
    if (extRun) extClk = ~extClk;
  end

  always @(negedge sclk) fallCnt++;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rxValid && rxReady) begin
      if (expQ.size() == 0) begin
        check(0, "unexpected word (R10/R7)", int'(rxData), 0);
      end else begin
        expT e;
        e = expQ.pop_front();
        check(rxData === e.d && rxAddr === e.a && rxParErr === e.p && rxFrmErr === e.f,
              e.tag, int'({rxAddr, rxParErr, rxFrmErr, rxData}), int'({e.a, e.p, e.f, e.d}));
      end
    end
  end

  task automatic pushExp(input logic [8:0] d, input logic a, input logic p, input logic f,
                         input string tag);
    expT e;
    e.d = d; e.a = a; e.p = p; e.f = f; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic sendTx(input logic [8:0] d, input logic a);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = d; txAddr = a; txValid = 1;
    @(negedge clk);
    txValid = 0;
  endtask

  task automatic waitDrain(input string req);
    for (int i = 0; i < 4000 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
    repeat (P) @(negedge clk);
  endtask

  task automatic rxBit(input logic v, input int n);
    @(negedge clk);
    benchRxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic driveFrame(input logic [8:0] d, input int len, input bit hasExt,
                            input logic ext, input bit stopOk);
    rxBit(0, P);
    for (int i = 0; i < len; i++) rxBit(d[i], P);
    if (hasExt) rxBit(ext, P);
    if (stopOk) rxBit(1, P);
    else begin rxBit(0, 48); rxBit(1, P); end
    rxBit(1, P);
  endtask

  task automatic decodeTx(input int per, input int nb, output logic [15:0] bits,
                          output int width);
    bits = '0; width = 0;
    for (int i = 0; i < 20 * per && txd !== 1'b0; i++) @(negedge clk);
    for (int c = 1; c <= per / 2 + nb * per; c++) begin
      @(negedge clk);
      if (width == 0 && txd === 1'b1) width = c;
      if (c >= per / 2 && (c - per / 2) % per == 0) bits[(c - per / 2) / per] = txd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] bits;
    int width;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(txd === 1 && sclk === 1, "R1 line idle", int'({txd, sclk}), 3);
    check(txReady === 1 && rxValid === 0 && rxOverrun === 0, "R1 handshake",
          int'({txReady, rxValid, rxOverrun}), 4);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R3 bit order and R4 reload timing
    fork sendTx(9'h0A5, 0); decodeTx(P, 9, bits, width); join
    check(bits[9:0] == {1'b1, 8'hA5, 1'b0}, "R3 frame bits", int'(bits[9:0]), int'({1'b1, 8'hA5, 1'b0}));
    check(width >= 58 && width <= 66, "R4 start width reload", width, P);
    repeat (2 * P) @(negedge clk);

    // R2 lengths in loopback
    loop = 1;
    cfgLenSel = 2'd0; pushExp(9'h05A, 0, 0, 0, "R2 seven bits"); sendTx(9'h15A, 0); waitDrain("R2 drain7");
    cfgLenSel = 2'd2; pushExp(9'h1A5, 0, 0, 0, "R2 nine bits"); sendTx(9'h1A5, 0); waitDrain("R2 drain9");
    cfgLenSel = 2'd3; pushExp(9'h0F3, 0, 0, 0, "R2 sel3 as nine"); sendTx(9'h0F3, 0); waitDrain("R2 drain3");

    // R5 parity in loopback
    cfgParEn = 1; cfgLenSel = 2'd0; cfgParOdd = 0;
    pushExp(9'h02D, 0, 0, 0, "R5 even six bits"); sendTx(9'h1ED, 0); waitDrain("R5 drain even");
    cfgLenSel = 2'd2; cfgParOdd = 1;
    pushExp(9'h0C3, 0, 0, 0, "R5 odd eight bits"); sendTx(9'h0C3, 0); waitDrain("R5 drain odd");

    // R5 parity error from the line
    loop = 0; cfgParOdd = 0;
    pushExp(9'h081, 0, 1, 0, "R5 bad parity flagged"); driveFrame(9'h081, 8, 1, 1, 1); waitDrain("R5 drain bad");

    // R6 framing error
    cfgParEn = 0; cfgLenSel = 2'd1;
    pushExp(9'h03C, 0, 0, 1, "R6 stop low flagged"); driveFrame(9'h03C, 8, 0, 0, 0); waitDrain("R6 drain");

    // R7 false start
    rxBit(0, 12); rxBit(1, 3 * P);
    check(rxValid === 0 && expQ.size() == 0, "R7 false start dropped", int'(rxValid), 0);

    // R9 overrun
    @(posedge clk); #1 rxReady = 0;
    driveFrame(9'h011, 8, 0, 0, 1);
    driveFrame(9'h022, 8, 0, 0, 1);
    check(rxValid === 1 && rxData === 9'h011, "R9 first word kept", int'(rxData), 'h11);
    check(rxOverrun === 1, "R9 overrun set", int'(rxOverrun), 1);
    pushExp(9'h011, 0, 0, 0, "R9 held word read");
    @(posedge clk); #1 rxReady = 1;
    repeat (3) @(negedge clk);
    check(rxValid === 0 && rxOverrun === 0, "R9 second word lost", int'({rxValid, rxOverrun}), 0);

    // R10 multiprocessor with wake filter
    loop = 1; cfgMulti = 1; cfgWake = 1;
    sendTx(9'h055, 0);
    repeat (12 * P + 50) @(negedge clk);
    check(rxValid === 0 && expQ.size() == 0, "R10 data frame filtered", int'(rxValid), 0);
    pushExp(9'h07E, 1, 0, 0, "R10 address frame"); sendTx(9'h07E, 1); waitDrain("R10 drain addr");
    cfgWake = 0;
    pushExp(9'h033, 0, 0, 0, "R10 data frame unfiltered"); sendTx(9'h033, 0); waitDrain("R10 drain data");
    cfgMulti = 0;

    // R8 and R12: double buffering and full duplex loopback
    pushExp(9'h001, 0, 0, 0, "R12 first looped word");
    pushExp(9'h0FE, 0, 0, 0, "R12 second looped word");
    sendTx(9'h001, 0);
    repeat (2) @(negedge clk);
    check(txReady === 1, "R8 ready while shifting", int'(txReady), 1);
    sendTx(9'h0FE, 0);
    repeat (20) @(negedge clk);
    check(txReady === 0, "R8 second word held", int'(txReady), 0);
    waitDrain("R12 drain");

    // R11 synchronous mode
    cfgSync = 1; fallCnt = 0;
    repeat (4) @(negedge clk);
    pushExp(9'h096, 0, 0, 0, "R11 sync loopback");
    sendTx(9'h096, 0);
    waitDrain("R11 drain");
    check(fallCnt == 8, "R11 one falling edge per bit", fallCnt, 8);
    check(sclk === 1, "R11 sclk idle high", int'(sclk), 1);
    cfgSync = 0; loop = 0;
    repeat (4) @(negedge clk);

    // R4 external clock
    cfgExtClk = 1; extRun = 1;
    fork sendTx(9'h0A5, 0); decodeTx(320, 9, bits, width); join
    check(width >= 298 && width <= 322, "R4 start width external", width, 320);
    check(bits[9:0] == {1'b1, 8'hA5, 1'b0}, "R4 external frame bits", int'(bits[9:0]), int'({1'b1, 8'hA5, 1'b0}));
    extRun = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule